// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the address for the beats of a burst access to a synchronous memory. When an access starts, the block captures the full address. During the burst it replaces the two least significant bits with a wrapping two-bit sequence and passes the upper bits through unchanged. A beat advances when the active-low advance input is low at a rising clock edge. The sequence never leaves the aligned group of four addresses that holds the start address.

A static mode input picks one of two orders. In interleaved order, each beat is the start value XORed with a beat count. In linear order, each beat is the start value plus the beat count, modulo four. The load pulse can come from either address strobe. A load always takes priority over an advance in the same cycle. Read bursts and write bursts use the same sequencing.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first cycle after it is released with no load, addr_out is all zeros.
- R2: A clock edge with load high captures addr_in. From the next cycle addr_out equals addr_in, for any value of the two low bits and in both orders.
- R3: When load is high, adv_n is ignored. A load with adv_n low gives the same addr_out as a load with adv_n high.
- R4: With load low and adv_n high at a clock edge, addr_out keeps its value.
- R5: With order_lin = 0 (interleaved), the low two bits of addr_out after k advances equal start XOR (k mod 4). A start of 01 gives 01, 00, 11, 10.
- R6: With order_lin = 1 (linear), the low two bits of addr_out after k advances equal (start + k) mod 4. A start of 01 gives 01, 10, 11, 00.
- R7: After the fourth advance the low bits return to the start value. Further advances repeat the same sequence.
- R8: Bits ADDR_W-1 down to 2 of addr_out equal the same bits of the last loaded address and do not change while the burst advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Start of access (from either address strobe); captures addr_in |
| addr_in | input | ADDR_W | Address presented at the start of an access |
| adv_n | input | 1 | Active-low advance to the next beat |
| order_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| addr_out | output | ADDR_W | Current beat address |

## Verification
The bench sweeps all four start values in both orders and runs eight advances from each start. This catches a design that uses the wrong order, mixes the two orders up, or fails to wrap back to the start after four beats. Every load is issued with adv_n low, so a design that lets the advance win over the load shows up with the first beat skipped. Idle cycles between advances expose a counter that moves without adv_n, and varying upper bits expose a carry out of bit 1 into the upper address.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adv_n,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int UPPER_LSB = 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic [1:0]        beat_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      step_q <= '0;
    end else if (!adv_n) begin
      step_q <= step_q + 2'd1;
    end
  end

  assign beat_lo  = order_lin ? (base_q[1:0] + step_q) : (base_q[1:0] ^ step_q);
  assign addr_out = {base_q[ADDR_W-1:UPPER_LSB], beat_lo};

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_out == $past(addr_in) || !$stable(order_lin)));

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> ($stable(addr_out) || !$stable(order_lin)));

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && order_lin) |=>
      (!order_lin || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  // R5
  interleave_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && !order_lin) |=>
      (order_lin || addr_out[0] != $past(addr_out[0])));

  // R8
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_out[ADDR_W-1:UPPER_LSB]));

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 20;
  localparam int WATCHDOG_CYCLES = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          adv_n = 1'b1;
  logic          order_lin = 1'b0;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_in),
    .adv_n(adv_n), .order_lin(order_lin), .addr_out(addr_out)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic [AW-1:0] a, input logic av_n);
    load = ld; addr_in = a; adv_n = av_n;
    @(negedge clk);
    load = 1'b0; adv_n = 1'b1;
  endtask

  initial begin
    #(20 * WATCHDOG_CYCLES);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] start;
    logic [AW-1:0] upper;
    logic [1:0]    lo;
    @(negedge clk);
    @(negedge clk);
    check("R1 in reset", '0);
    rst_n = 1'b1;
    cycle(1'b0, '0, 1'b1);
    check("R1 after reset", '0);

    for (int m = 0; m < 2; m++) begin
      order_lin = m[0];
      for (int s = 0; s < 4; s++) begin
        upper = AW'((s * 32'h1357 + m * 32'h2a5) << 2) | AW'(32'hC0000);
        start = upper | AW'(s);
        cycle(1'b1, start, 1'b0);
        check("R2/R3 load overrides advance", start);
        cycle(1'b0, '0, 1'b1);
        check("R4 hold on idle", start);
        for (int k = 1; k <= 8; k++) begin
          cycle(1'b0, '0, 1'b0);
          if (m == 0) lo = 2'(s ^ (k % 4));
          else        lo = 2'((s + k) % 4);
          if (k % 4 == 0) check("R7 wrap to start", {upper[AW-1:2], lo});
          else if (m == 0) check("R5 interleaved beat", {upper[AW-1:2], lo});
          else check("R6 linear beat", {upper[AW-1:2], lo});
          if (k == 3) begin
            cycle(1'b0, '0, 1'b1);
            check("R4 hold mid-burst", {upper[AW-1:2], lo});
          end
        end
        check("R8 upper bits kept", {upper[AW-1:2], lo});
      end
    end

    order_lin = 1'b1;
    cycle(1'b1, AW'(32'h00003), 1'b0);
    cycle(1'b0, '0, 1'b0);
    check("R8 no carry into upper bits", AW'(32'h00000));

    rst_n = 1'b0;
    cycle(1'b0, '0, 1'b0);
    check("R1 reset mid-run", '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule